// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status and Summary Unit

This block keeps the interrupt bookkeeping of an Ethernet controller. Event pulses from the transmit, receive, link and bus logic set sticky bits in a 32-bit status word. A 32-bit enable word decides which pending events count towards two summary bits. One summary covers the routine events and the other covers the abnormal ones. A level interrupt line to the host is raised when an enabled summary is set.

The host reaches both words over a simple single-cycle register bus. The status word is write-one-to-clear: only bits written as 1 are cleared. The enable word is a plain read/write register. The status word also carries two 3-bit progress fields, one for the receive process and one for the transmit process. Those engines load the fields through their own strobes, and host writes cannot change them. A soft-reset pulse returns every register to its power-up value.

Summaries and the interrupt line are registered. They are derived from the values that the event and enable registers take on the same clock edge. The host therefore never reads a status word that disagrees with the interrupt line.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word reads 0xF0000000, the enable word reads 0xF3FE0000 and `irqOut` is 0.
- R2: A 1 on `evtSet` at an event position sets that status bit at the next clock edge. The event positions are bits 0 to 14, 26 and 27. A 1 at any other position is ignored, and the status word is unchanged by it.
- R3: A host write to the status word (address 0) clears each event bit written as 1 and leaves bits written as 0 unchanged. It never alters the receive-state field (bits 19:17), the transmit-state field (bits 22:20), bits 25:23 (always 0) or bits 31:28 (always 1).
- R4: Status bit 16, the routine summary, is 1 exactly when at least one event is both pending and enabled in the routine group. The routine group is bits 0, 2, 6, 11 and 14.
- R5: Status bit 15, the abnormal summary, is 1 exactly when at least one event is both pending and enabled in the abnormal group. The abnormal group is bits 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 and 27.
- R6: The summaries are derived again on every clock edge. Writing 1 to a summary bit while a qualifying event is still pending leaves that summary set.
- R7: `irqOut` is 1 exactly when (status bit 15 AND enable bit 15) OR (status bit 16 AND enable bit 16). It changes on the same edge as the status word.
- R8: A host write to the enable word (address 1) stores all 32 bits. The new enables take effect on the summaries and on `irqOut` at that same edge.
- R9: When an event pulse and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `rxStateLoad` loads `rxStateIn` into bits 19:17, and `txStateLoad` loads `txStateIn` into bits 22:20. Without a load strobe the fields hold their value.
- R11: A `softRst` pulse restores the reset values of R1, with both state fields 0, at the next edge. It overrides any event, write or load in the same cycle.
- R12: Reads of any address other than 0 and 1 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous soft-reset pulse |
| evtSet | input | 32 | Single-cycle event pulses, aligned to status bit positions |
| rxStateLoad | input | 1 | Load strobe for the receive-state field |
| rxStateIn | input | 3 | New receive-state value |
| txStateLoad | input | 1 | Load strobe for the transmit-state field |
| txStateIn | input | 3 | New transmit-state value |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | ADDR_W | Host word address (0 status, 1 enable) |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Host read data, combinational from `regAddr` |
| irqOut | output | 1 | Registered level interrupt |

## Verification
A lost or stale event bit shows in the status word read back one cycle after the pulse or write. Through the summaries, the same fault shows on `irqOut` on that edge. A summary derived from an old enable or event value shows as a mismatch between `irqOut` and a status read in the cycle right after the change. The bench compares the whole status word and the interrupt line against a model after every stimulus step. Corrupted state fields, or state fields that a host write disturbs, therefore appear at the first read that follows.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned STATE_W = 3;

  // Bit placement inside the status word (decoded by host software)
  localparam int unsigned SUM_ABN_BIT  = 15;
  localparam int unsigned SUM_NORM_BIT = 16;
  localparam int unsigned RX_LSB       = 17;
  localparam int unsigned TX_LSB       = 20;

  localparam logic [WORD_W-1:0] EVT_BITS   = 32'h0C00_7FFF;
  localparam logic [WORD_W-1:0] NORM_GRP   = 32'h0000_4845;
  localparam logic [WORD_W-1:0] ABN_GRP    = EVT_BITS & ~NORM_GRP;
  localparam logic [WORD_W-1:0] FIXED_ONES = 32'hF000_0000;
  localparam logic [WORD_W-1:0] MASK_RST   = 32'hF3FE_0000;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic softRst;
    logic rxLoad;
    logic txLoad;
  } strobe_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdsel_t;

endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned STATUS_ADDR = 0,
  parameter int unsigned MASK_ADDR   = 1
) (
  input  logic              softRst,
  input  logic              rxStateLoad,
  input  logic              txStateLoad,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output rdsel_t            rdSel
);

  localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] MK_A = ADDR_W'(MASK_ADDR);

  logic hitStatus;
  logic hitMask;

  assign hitStatus = (regAddr == ST_A);
  assign hitMask   = (regAddr == MK_A);

  // Soft reset masks every other strobe so the datapath sees one cause
  always_comb begin
    strb.softRst  = softRst;
    strb.wrStatus = regWrEn & hitStatus & ~softRst;
    strb.wrMask   = regWrEn & hitMask & ~softRst;
    strb.rxLoad   = rxStateLoad & ~softRst;
    strb.txLoad   = txStateLoad & ~softRst;
  end

  always_comb begin
    if (hitStatus)    rdSel = RD_STATUS;
    else if (hitMask) rdSel = RD_MASK;
    else              rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  rdsel_t             rdSel,
  input  logic [WORD_W-1:0]  evtSet,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [STATE_W-1:0] rxStateIn,
  input  logic [STATE_W-1:0] txStateIn,
  output logic [WORD_W-1:0]  rdData,
  output logic               irqOut
);

  logic [WORD_W-1:0]  evtQ;
  logic [WORD_W-1:0]  evtNext;
  logic [WORD_W-1:0]  maskQ;
  logic [WORD_W-1:0]  maskNext;
  logic [WORD_W-1:0]  pendEn;
  logic [STATE_W-1:0] rxStateQ;
  logic [STATE_W-1:0] txStateQ;
  logic               nisQ;
  logic               aisQ;
  logic               irqQ;
  logic               nisNext;
  logic               aisNext;
  logic               irqNext;
  logic [WORD_W-1:0]  statusWord;

  // Per-bit sticky event logic; non-event positions are tied low
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (EVT_BITS[i]) begin : g_evt
      assign evtNext[i] = evtSet[i] | (evtQ[i] & ~(strb.wrStatus & wrData[i]));
    end else begin : g_fixed
      assign evtNext[i] = 1'b0;
    end
  end

  assign maskNext = strb.wrMask ? wrData : maskQ;
  assign pendEn   = evtNext & maskNext;
  assign nisNext  = |(pendEn & NORM_GRP);
  assign aisNext  = |(pendEn & ABN_GRP);
  assign irqNext  = (nisNext & maskNext[SUM_NORM_BIT]) | (aisNext & maskNext[SUM_ABN_BIT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ <= '0;
      maskQ <= MASK_RST;
      nisQ <= 1'b0;
      aisQ <= 1'b0;
      irqQ <= 1'b0;
    end else if (strb.softRst) begin
      evtQ <= '0;
      maskQ <= MASK_RST;
      nisQ <= 1'b0;
      aisQ <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      evtQ <= evtNext;
      maskQ <= maskNext;
      nisQ <= nisNext;
      aisQ <= aisNext;
      irqQ <= irqNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStateQ <= '0;
      txStateQ <= '0;
    end else if (strb.softRst) begin
      rxStateQ <= '0;
      txStateQ <= '0;
    end else begin
      if (strb.rxLoad) rxStateQ <= rxStateIn;
      if (strb.txLoad) txStateQ <= txStateIn;
    end
  end

  always_comb begin
    statusWord = FIXED_ONES | evtQ;
    statusWord[RX_LSB +: STATE_W] = rxStateQ;
    statusWord[TX_LSB +: STATE_W] = txStateQ;
    statusWord[SUM_NORM_BIT] = nisQ;
    statusWord[SUM_ABN_BIT] = aisQ;
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdData = statusWord;
      RD_MASK:   rdData = maskQ;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  // R7: interrupt only through an enabled, set summary
  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> ((statusWord[SUM_NORM_BIT] & maskQ[SUM_NORM_BIT]) |
              (statusWord[SUM_ABN_BIT] & maskQ[SUM_ABN_BIT])));

  // R4: routine summary needs an enabled pending routine event
  p_norm_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    nisQ |-> (|(evtQ & maskQ & NORM_GRP)));

  // R5: abnormal summary needs an enabled pending abnormal event
  p_abn_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    aisQ |-> (|(evtQ & maskQ & ABN_GRP)));

  // R9: a pulse always lands, even against a host clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.softRst && (|(evtSet & EVT_BITS))) |=>
      ((evtQ & $past(evtSet & EVT_BITS)) == $past(evtSet & EVT_BITS)));

  // R3: written ones without a matching pulse are cleared
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && !strb.softRst) |=>
      ((evtQ & $past(wrData & ~evtSet & EVT_BITS)) == '0));

  // R10: state fields hold without their load strobe
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rxLoad && !strb.softRst) |=> $stable(rxStateQ));

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txLoad && !strb.softRst) |=> $stable(txStateQ));

  // R8: enable write stores the full word
  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMask && !strb.softRst) |=> (maskQ == $past(wrData)));

  // R11: soft reset returns the enable word and drops the interrupt
  p_soft_rst_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (maskQ == MASK_RST && !irqQ && evtQ == '0));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned STATUS_ADDR = 0,
  parameter int unsigned MASK_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [31:0]       evtSet,
  input  logic              rxStateLoad,
  input  logic [2:0]        rxStateIn,
  input  logic              txStateLoad,
  input  logic [2:0]        txStateIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut
);

  strobe_t strb;
  rdsel_t  rdSel;

  irq_status_ctrl #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .MASK_ADDR   (MASK_ADDR)
  ) u_ctrl (
    .softRst     (softRst),
    .rxStateLoad (rxStateLoad),
    .txStateLoad (txStateLoad),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .strb        (strb),
    .rdSel       (rdSel)
  );

  irq_status_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .evtSet    (evtSet),
    .wrData    (regWrData),
    .rxStateIn (rxStateIn),
    .txStateIn (txStateIn),
    .rdData    (regRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;

  localparam logic [31:0] EVT  = 32'h0C00_7FFF;
  localparam logic [31:0] NORM = 32'h0000_4845;
  localparam logic [31:0] ABN  = 32'h0C00_37BA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic [31:0] evtSet = '0;
  logic        rxStateLoad = 1'b0;
  logic [2:0]  rxStateIn = '0;
  logic        txStateLoad = 1'b0;
  logic [2:0]  txStateIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [2:0]  monAddr = '0;
  logic [2:0]  regAddr;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  assign regAddr = regWrEn ? wrAddr : monAddr;

  always #5 clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .evtSet(evtSet),
    .rxStateLoad(rxStateLoad), .rxStateIn(rxStateIn),
    .txStateLoad(txStateLoad), .txStateIn(txStateIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] expData;
    logic        expIrq;
    string       tag;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  int target = 0;
  int doneCnt = 0;
  bit finished = 0;

  // Model state, built from the requirements
  logic [31:0] mEvt, mMask;
  logic [2:0]  mRx, mTx;
  logic        mNis, mAis, mIrq;

  function automatic logic [31:0] modelStatus();
    logic [31:0] s;
    s = 32'hF000_0000 | mEvt;
    s[19:17] = mRx;
    s[22:20] = mTx;
    s[16] = mNis;
    s[15] = mAis;
    return s;
  endfunction

  task automatic modelReset();
    mEvt = '0; mMask = 32'hF3FE_0000; mRx = '0; mTx = '0;
    mNis = 0; mAis = 0; mIrq = 0;
  endtask

  // Drive one cycle of stimulus from a negedge, update the model at the edge
  task automatic step(input logic [31:0] set, input bit wrEn, input logic [2:0] a,
                      input logic [31:0] d, input bit rxL, input logic [2:0] rxV,
                      input bit txL, input logic [2:0] txV, input bit sr);
    logic [31:0] pe;
    evtSet = set; regWrEn = wrEn; wrAddr = a; regWrData = d;
    rxStateLoad = rxL; rxStateIn = rxV; txStateLoad = txL; txStateIn = txV;
    softRst = sr;
    @(posedge clk);
    if (sr) modelReset();
    else begin
      if (wrEn && a == 3'd1) mMask = d;
      if (wrEn && a == 3'd0) mEvt = mEvt & ~d;
      mEvt = (mEvt | set) & EVT;
      if (rxL) mRx = rxV;
      if (txL) mTx = txV;
      pe = mEvt & mMask;
      mNis = |(pe & NORM);
      mAis = |(pe & ABN);
      mIrq = (mNis & mMask[16]) | (mAis & mMask[15]);
    end
    @(negedge clk);
    evtSet = '0; regWrEn = 0; regWrData = '0; rxStateLoad = 0; txStateLoad = 0; softRst = 0;
  endtask

  task automatic pulse(input logic [31:0] set);
    step(set, 0, 3'd0, '0, 0, 3'd0, 0, 3'd0, 0);
  endtask

  task automatic hostWr(input logic [2:0] a, input logic [31:0] d);
    step('0, 1, a, d, 0, 3'd0, 0, 3'd0, 0);
  endtask

  task automatic check(input logic [2:0] a, input string tag);
    item_t it;
    it.addr = a;
    it.expData = (a == 3'd0) ? modelStatus() : (a == 3'd1) ? mMask : 32'h0;
    it.expIrq = mIrq;
    it.tag = tag;
    sbq.push_back(it);
    target++;
    wait (doneCnt == target);
  endtask

  // Monitor: pops expected items and compares at the negedge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sbq.size() != 0) begin
        it = sbq.pop_front();
        monAddr = it.addr;
        #1;
        checks++;
        if (regRdData !== it.expData || irqOut !== it.expIrq) begin
          errors++;
          $display("FAIL %s addr=%0d data=%h irq=%b expected data=%h irq=%b",
                   it.tag, it.addr, regRdData, irqOut, it.expData, it.expIrq);
        end
        doneCnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    check(3'd0, "R1 status reset");
    check(3'd1, "R1 mask reset");

    pulse(32'h0000_0001);
    check(3'd0, "R2 event set");
    pulse(32'h00FF_8000);
    check(3'd0, "R2 non-event ignored");

    hostWr(3'd1, 32'hFFFF_FFFF);
    check(3'd1, "R8 mask readback");
    check(3'd0, "R4 routine summary after mask write R8");

    hostWr(3'd0, 32'h0001_8000);
    check(3'd0, "R6 summary rederived");

    step('0, 0, 3'd0, '0, 1, 3'd3, 1, 3'd6, 0);
    check(3'd0, "R10 state load");
    hostWr(3'd0, 32'hFFFF_FFFF);
    check(3'd0, "R3 clear all keeps state fields");

    pulse(32'h0800_2000);
    check(3'd0, "R5 abnormal summary");

    hostWr(3'd1, 32'h0C00_7FFF);
    check(3'd0, "R7 summaries set but not enabled");
    hostWr(3'd1, 32'h0C00_FFFF);
    check(3'd0, "R7 abnormal summary enabled");

    hostWr(3'd0, 32'h0000_2000);
    check(3'd0, "R3 partial clear");

    step(32'h0000_0040, 1, 3'd0, 32'h0800_0040, 0, 3'd0, 0, 3'd0, 0);
    check(3'd0, "R9 set wins over clear");

    step('0, 0, 3'd0, '0, 1, 3'd5, 1, 3'd2, 0);
    hostWr(3'd0, 32'h007E_0000);
    check(3'd0, "R10 host write cannot change state");

    hostWr(3'd5, 32'hFFFF_FFFF);
    check(3'd5, "R12 unmapped read zero");
    check(3'd0, "R12 unmapped write no effect");
    check(3'd1, "R12 unmapped write mask unchanged");

    step(32'h0000_4845, 1, 3'd1, 32'h0, 1, 3'd7, 0, 3'd0, 1);
    check(3'd0, "R11 soft reset status");
    check(3'd1, "R11 soft reset mask");

    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 40; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      case (lfsr[1:0])
        2'd0: step(lfsr & 32'h0C00_4845, 1, 3'd0, {lfsr[15:0], lfsr[31:16]}, 0, 3'd0, 0, 3'd0, 0);
        2'd1: step('0, 1, 3'd1, {lfsr[7:0], lfsr[31:8]}, 0, 3'd0, 0, 3'd0, 0);
        2'd2: pulse(lfsr);
        default: step(lfsr & 32'h0000_37BA, 0, 3'd0, '0, lfsr[4], lfsr[7:5], lfsr[8], lfsr[11:9], 0);
      endcase
      check(3'd0, "R4 R5 R7 mixed pattern");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule